// File: doc/BRIEF.md
# ISA 8-bit to IDE 16-bit Bridge

This block sits between an 8-bit ISA-style I/O bus and the 16-bit register interface of an IDE (ATA) drive. A 16-byte I/O window, placed by a 4-bit jumper input, is mapped onto the drive's command and control register blocks. A strap input selects one of two offset layouts. Sixteen-bit data words are carried over the narrow bus by two high-byte holding registers, one per direction. Their order of use is fixed: a data read fills the read holder, and a data-high write must come before the data write that uses it.

The bridge also decodes a 16 KB option-ROM window, placed by a second 4-bit jumper input, and reports hits with the offset inside the window. It routes the drive interrupt to one of five ISA IRQ lines. Every drive access drives one chip select and a 3-bit register address for a parameterised number of strobe cycles. The bus acknowledge is held back until the strobe has finished. Accesses that involve no drive cycle are acknowledged on the next cycle.

Top module: `isa8_ide_bridge`

## Requirements
- R1: An I/O request is claimed only when bus_addr[15:0] lies in [0x200 + 0x20*io_jmp, 0x200 + 0x20*io_jmp + 15]. An unclaimed request gets no bus_ack and causes no drive strobe.
- R2: A read at the data offset returns bits [7:0] of ide_rdata. Bits [15:8] are stored in the read holder in the same drive cycle.
- R3: A read at the data-high offset returns the read holder and causes no drive strobe. Repeated reads return the same byte until the next data read.
- R4: A write at the data-high offset only loads the write holder. A write at the data offset drives ide_wdata = {write holder, bus byte} in a single drive write.
- R5: With layout_b=0, the offsets map as follows. Offset 0 is data (command block register 0). Offsets 1..7 go to command-block registers 1..7. Offset 8 is data-high. Offset 14 goes to control-block register 6.
- R6: With layout_b=1, the offsets map as follows. Offset 0 is data and offset 1 is data-high. Offsets 2, 4 and 6 go to command registers 2, 4 and 6. Offset 7 goes to control register 6. Offsets 8, 10, 12 and 14 go to command registers 1, 3, 5 and 7.
- R7: Offsets that are unused in the active layout read 0x00. Writes to them are acknowledged but cause no drive strobe and change no holder.
- R8: A drive access raises either ide_rd or ide_wr, never both, for exactly STROBE_CYC cycles. During that time exactly one of ide_cs_cmd and ide_cs_ctl is set and ide_reg is stable. bus_ack pulses in the cycle right after the strobe. An access with no drive cycle is acknowledged on the cycle after the request. For registers other than data, a write drives the high byte of ide_wdata to 0x00.
- R9: rom_sel is high exactly when mem_rd_req is set and bus_addr lies in [0xC0000 + 0x4000*rom_jmp, +0x3FFF]. rom_offs is bus_addr[13:0].
- R10: irq_lines bits 0..4 stand for IRQ 2, 3, 4, 5 and 7. Only the bit whose number equals irq_sel follows ide_irq. Any other irq_sel value keeps all bits at 0.
- R11: After reset both holders are 0x00, and no strobe or acknowledge is active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 20 | Bus address (I/O uses bits 15:0) |
| io_rd_req | input | 1 | One-cycle I/O read request |
| io_wr_req | input | 1 | One-cycle I/O write request |
| mem_rd_req | input | 1 | Memory read qualifier for ROM decode |
| bus_wdata | input | 8 | Bus write byte |
| bus_rdata | output | 8 | Bus read byte, valid with bus_ack |
| bus_ack | output | 1 | One-cycle completion of a claimed I/O request |
| io_jmp | input | 4 | I/O window jumper |
| rom_jmp | input | 4 | ROM window jumper |
| irq_sel | input | 3 | IRQ number selection |
| layout_b | input | 1 | Register layout strap |
| rom_sel | output | 1 | ROM window hit |
| rom_offs | output | 14 | Offset inside ROM window |
| ide_cs_cmd | output | 1 | Command-block chip select (active high) |
| ide_cs_ctl | output | 1 | Control-block chip select (active high) |
| ide_reg | output | 3 | Drive register address |
| ide_wdata | output | 16 | Drive write word |
| ide_rdata | input | 16 | Drive read word |
| ide_rd | output | 1 | Drive read strobe |
| ide_wr | output | 1 | Drive write strobe |
| ide_irq | input | 1 | Drive interrupt request |
| irq_lines | output | 5 | IRQ 2,3,4,5,7 outputs |

## Verification
A wrong holder value stays hidden until it is used. A bad read holder shows on the next data-high read, and a bad write holder shows in the high byte of the next data write. The bench therefore follows every holder update with an access that exposes it. A wrong offset map or window compare shows within one request, as a strobe on the wrong select or register, or as an acknowledge that is missing or should not be there. Errors in the engine's counter or state show within STROBE_CYC+1 cycles, as a wrong strobe length or an acknowledge that comes too early or too late.

// File: rtl/isa_ide_pkg.sv
package isa_ide_pkg;

    typedef enum logic [2:0] {
        ACC_NONE,
        ACC_DATA,
        ACC_DHI,
        ACC_CMD,
        ACC_CTL
    } acc_kind_e;

    typedef struct packed {
        acc_kind_e  kind;
        logic [2:0] reg_idx;
    } reg_slot_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_STROBE,
        ST_ACK
    } eng_state_e;

    localparam logic [2:0] CTL_REG_IDX = 3'd6;
    localparam int         IRQ_LINES   = 5;

    function automatic reg_slot_t mk_slot(input acc_kind_e k, input logic [2:0] r);
        reg_slot_t s;
        s.kind    = k;
        s.reg_idx = r;
        return s;
    endfunction

    function automatic reg_slot_t map_offset(input logic alt_layout, input logic [3:0] offs);
        reg_slot_t s;
        s = mk_slot(ACC_NONE, 3'd0);
        if (!alt_layout) begin
            if (offs == 4'd0)       s = mk_slot(ACC_DATA, 3'd0);
            else if (offs < 4'd8)   s = mk_slot(ACC_CMD, offs[2:0]);
            else if (offs == 4'd8)  s = mk_slot(ACC_DHI, 3'd0);
            else if (offs == 4'd14) s = mk_slot(ACC_CTL, CTL_REG_IDX);
        end else begin
            case (offs)
                4'd0:    s = mk_slot(ACC_DATA, 3'd0);
                4'd1:    s = mk_slot(ACC_DHI, 3'd0);
                4'd7:    s = mk_slot(ACC_CTL, CTL_REG_IDX);
                4'd2, 4'd4, 4'd6:
                         s = mk_slot(ACC_CMD, offs[2:0]);
                4'd8, 4'd10, 4'd12, 4'd14:
                         s = mk_slot(ACC_CMD, {offs[2:1], 1'b1});
                default: s = mk_slot(ACC_NONE, 3'd0);
            endcase
        end
        return s;
    endfunction

    function automatic logic [2:0] irq_line_num(input int idx);
        case (idx)
            0:       return 3'd2;
            1:       return 3'd3;
            2:       return 3'd4;
            3:       return 3'd5;
            default: return 3'd7;
        endcase
    endfunction

endpackage

// File: rtl/isa_ide_decode.sv
module isa_ide_decode
    import isa_ide_pkg::*;
#(
    parameter int          ADDR_W      = 20,
    parameter int          JMP_W       = 4,
    parameter logic [15:0] IO_BASE     = 16'h0200,
    parameter int          IO_STEP_LG2 = 5,
    parameter logic [19:0] ROM_BASE    = 20'hC0000,
    parameter int          ROM_AW      = 14
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [JMP_W-1:0]  io_jmp,
    input  logic [JMP_W-1:0]  rom_jmp,
    input  logic              alt_layout,
    output logic              io_hit,
    output reg_slot_t         slot,
    output logic              rom_hit,
    output logic [ROM_AW-1:0] rom_offs
);
    localparam int OFF_W = 4;

    logic [15:0]       io_start;
    logic [ADDR_W-1:0] rom_start;

    always_comb begin
        io_start  = IO_BASE + (16'(io_jmp) << IO_STEP_LG2);
        rom_start = ROM_BASE + (ADDR_W'(rom_jmp) << ROM_AW);
        io_hit    = (addr[15:OFF_W] == io_start[15:OFF_W]);
        rom_hit   = (addr[ADDR_W-1:ROM_AW] == rom_start[ADDR_W-1:ROM_AW]);
        rom_offs  = addr[ROM_AW-1:0];
        slot      = map_offset(alt_layout, addr[OFF_W-1:0]);
    end
endmodule

// File: rtl/isa_ide_holders.sv
module isa_ide_holders #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_rd,
    input  logic [BYTE_W-1:0] rd_in,
    input  logic              ld_wr,
    input  logic [BYTE_W-1:0] wr_in,
    output logic [BYTE_W-1:0] rd_hold,
    output logic [BYTE_W-1:0] wr_hold
);
    always_ff @(posedge clk) begin
        if (rst) begin
            rd_hold <= '0;
            wr_hold <= '0;
        end else begin
            if (ld_rd) rd_hold <= rd_in;
            if (ld_wr) wr_hold <= wr_in;
        end
    end
endmodule

// File: rtl/isa_ide_engine.sv
module isa_ide_engine
    import isa_ide_pkg::*;
#(
    parameter int STROBE_CYC = 3,
    parameter int BYTE_W     = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                is_wr,
    input  reg_slot_t           slot,
    input  logic [BYTE_W-1:0]   wbyte,
    input  logic [2*BYTE_W-1:0] ide_rdata,
    input  logic [BYTE_W-1:0]   rd_hold,
    input  logic [BYTE_W-1:0]   wr_hold,
    output logic                ld_rd,
    output logic                ld_wr,
    output logic                idle,
    output logic                bus_ack,
    output logic [BYTE_W-1:0]   bus_rdata,
    output logic                ide_cs_cmd,
    output logic                ide_cs_ctl,
    output logic [2:0]          ide_reg,
    output logic [2*BYTE_W-1:0] ide_wdata,
    output logic                ide_rd,
    output logic                ide_wr
);
    localparam int CNT_W = (STROBE_CYC < 2) ? 1 : $clog2(STROBE_CYC);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(STROBE_CYC - 1);

    eng_state_e          state;
    logic [CNT_W-1:0]    cnt;
    logic                cur_wr;
    logic                cur_ctl;
    logic                cur_data;
    logic [2:0]          cur_reg;
    logic [2*BYTE_W-1:0] out_word;
    logic [BYTE_W-1:0]   rsp_byte;
    logic                drive_acc;
    logic                strobe_end;

    always_comb begin
        idle       = (state == ST_IDLE);
        drive_acc  = (slot.kind == ACC_DATA) || (slot.kind == ACC_CMD) || (slot.kind == ACC_CTL);
        strobe_end = (state == ST_STROBE) && (cnt == CNT_LAST);
        ld_wr      = idle && start && is_wr && (slot.kind == ACC_DHI);
        ld_rd      = strobe_end && !cur_wr && cur_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cnt      <= '0;
            cur_wr   <= 1'b0;
            cur_ctl  <= 1'b0;
            cur_data <= 1'b0;
            cur_reg  <= '0;
            out_word <= '0;
            rsp_byte <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (start) begin
                        if (drive_acc) begin
                            state    <= ST_STROBE;
                            cnt      <= '0;
                            cur_wr   <= is_wr;
                            cur_ctl  <= (slot.kind == ACC_CTL);
                            cur_data <= (slot.kind == ACC_DATA);
                            cur_reg  <= slot.reg_idx;
                            out_word <= (slot.kind == ACC_DATA) ? {wr_hold, wbyte}
                                                                : {{BYTE_W{1'b0}}, wbyte};
                        end else begin
                            state    <= ST_ACK;
                            rsp_byte <= (!is_wr && slot.kind == ACC_DHI) ? rd_hold : '0;
                        end
                    end
                end
                ST_STROBE: begin
                    if (cnt == CNT_LAST) begin
                        state    <= ST_ACK;
                        rsp_byte <= cur_wr ? '0 : ide_rdata[BYTE_W-1:0];
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        ide_rd     = (state == ST_STROBE) && !cur_wr;
        ide_wr     = (state == ST_STROBE) && cur_wr;
        ide_cs_cmd = (state == ST_STROBE) && !cur_ctl;
        ide_cs_ctl = (state == ST_STROBE) && cur_ctl;
        ide_reg    = cur_reg;
        ide_wdata  = out_word;
        bus_ack    = (state == ST_ACK);
        bus_rdata  = bus_ack ? rsp_byte : '0;
    end
endmodule

// File: rtl/isa_ide_irq_route.sv
module isa_ide_irq_route
    import isa_ide_pkg::*;
(
    input  logic                 ide_irq,
    input  logic [2:0]           irq_sel,
    output logic [IRQ_LINES-1:0] irq_lines
);
    for (genvar g = 0; g < IRQ_LINES; g++) begin : g_line
        assign irq_lines[g] = ide_irq && (irq_sel == irq_line_num(g));
    end
endmodule

// File: rtl/isa8_ide_bridge.sv
module isa8_ide_bridge
    import isa_ide_pkg::*;
#(
    parameter int          STROBE_CYC = 3,
    parameter logic [15:0] IO_BASE    = 16'h0200,
    parameter logic [19:0] ROM_BASE   = 20'hC0000,
    parameter int          ROM_AW     = 14
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [19:0]       bus_addr,
    input  logic              io_rd_req,
    input  logic              io_wr_req,
    input  logic              mem_rd_req,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              bus_ack,
    input  logic [3:0]        io_jmp,
    input  logic [3:0]        rom_jmp,
    input  logic [2:0]        irq_sel,
    input  logic              layout_b,
    output logic              rom_sel,
    output logic [ROM_AW-1:0] rom_offs,
    output logic              ide_cs_cmd,
    output logic              ide_cs_ctl,
    output logic [2:0]        ide_reg,
    output logic [15:0]       ide_wdata,
    input  logic [15:0]       ide_rdata,
    output logic              ide_rd,
    output logic              ide_wr,
    input  logic              ide_irq,
    output logic [4:0]        irq_lines
);
    localparam int BYTE_W = 8;

    logic              io_hit;
    logic              rom_hit;
    reg_slot_t         slot;
    logic              idle;
    logic              start;
    logic              ld_rd;
    logic              ld_wr;
    logic [BYTE_W-1:0] rd_hold;
    logic [BYTE_W-1:0] wr_hold;

    isa_ide_decode #(
        .ADDR_W(20), .JMP_W(4), .IO_BASE(IO_BASE), .IO_STEP_LG2(5),
        .ROM_BASE(ROM_BASE), .ROM_AW(ROM_AW)
    ) u_decode (
        .addr(bus_addr), .io_jmp(io_jmp), .rom_jmp(rom_jmp), .alt_layout(layout_b),
        .io_hit(io_hit), .slot(slot), .rom_hit(rom_hit), .rom_offs(rom_offs)
    );

    assign start   = (io_rd_req || io_wr_req) && io_hit && idle;
    assign rom_sel = mem_rd_req && rom_hit;

    isa_ide_holders #(.BYTE_W(BYTE_W)) u_holders (
        .clk(clk), .rst(rst),
        .ld_rd(ld_rd), .rd_in(ide_rdata[2*BYTE_W-1:BYTE_W]),
        .ld_wr(ld_wr), .wr_in(bus_wdata),
        .rd_hold(rd_hold), .wr_hold(wr_hold)
    );

    isa_ide_engine #(.STROBE_CYC(STROBE_CYC), .BYTE_W(BYTE_W)) u_engine (
        .clk(clk), .rst(rst), .start(start), .is_wr(io_wr_req), .slot(slot),
        .wbyte(bus_wdata), .ide_rdata(ide_rdata), .rd_hold(rd_hold), .wr_hold(wr_hold),
        .ld_rd(ld_rd), .ld_wr(ld_wr), .idle(idle), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
        .ide_cs_cmd(ide_cs_cmd), .ide_cs_ctl(ide_cs_ctl), .ide_reg(ide_reg),
        .ide_wdata(ide_wdata), .ide_rd(ide_rd), .ide_wr(ide_wr)
    );

    isa_ide_irq_route u_irq (
        .ide_irq(ide_irq), .irq_sel(irq_sel), .irq_lines(irq_lines)
    );
endmodule

// File: rtl/isa8_ide_bridge_chk.sv
module isa8_ide_bridge_chk (
    input logic       clk,
    input logic       rst,
    input logic       ide_rd,
    input logic       ide_wr,
    input logic       ide_cs_cmd,
    input logic       ide_cs_ctl,
    input logic [2:0] ide_reg,
    input logic       ide_irq,
    input logic [4:0] irq_lines,
    input logic       bus_ack
);
    assert_rd_wr_excl_R8: assert property (@(posedge clk) disable iff (rst)
        !(ide_rd && ide_wr));

    assert_one_select_R8: assert property (@(posedge clk) disable iff (rst)
        (ide_rd || ide_wr) |-> ($countones({ide_cs_cmd, ide_cs_ctl}) == 1));

    assert_reg_stable_R8: assert property (@(posedge clk) disable iff (rst)
        ((ide_rd || ide_wr) && ($past(ide_rd) || $past(ide_wr))) |-> $stable(ide_reg));

    assert_ack_after_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        ($fell(ide_rd) || $fell(ide_wr)) |-> bus_ack);

    assert_no_ack_in_strobe_R8: assert property (@(posedge clk) disable iff (rst)
        (ide_rd || ide_wr) |-> !bus_ack);

    assert_irq_single_R10: assert property (@(posedge clk) disable iff (rst)
        $onehot0(irq_lines));

    assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (rst)
        !ide_irq |-> (irq_lines == 5'd0));
endmodule

bind isa8_ide_bridge isa8_ide_bridge_chk u_chk (.*);

// File: tb/isa8_ide_bridge_tb.sv
module isa8_ide_bridge_tb;
    localparam int S = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [19:0] bus_addr = '0;
    logic        io_rd_req = 1'b0, io_wr_req = 1'b0, mem_rd_req = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic        bus_ack;
    logic [3:0]  io_jmp = 4'd8, rom_jmp = 4'd2;
    logic [2:0]  irq_sel = 3'd5;
    logic        layout_b = 1'b0;
    logic        rom_sel;
    logic [13:0] rom_offs;
    logic        ide_cs_cmd, ide_cs_ctl, ide_rd, ide_wr, ide_irq = 1'b0;
    logic [2:0]  ide_reg;
    logic [15:0] ide_wdata, ide_rdata = '0;
    logic [4:0]  irq_lines;

    int checks = 0, errors = 0;
    logic [7:0] m_rd = 8'h00, m_wr = 8'h00;

    always #4 clk = ~clk;

    isa8_ide_bridge #(.STROBE_CYC(S)) u_dut (.*);

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // -1 unused, 16 data, 17 data-high, 0..7 command register, 14 control register 6
    function automatic int exp_code(input bit lb, input int off);
        if (!lb) begin
            if (off == 0) return 16;
            if (off <= 7) return off;
            if (off == 8) return 17;
            if (off == 14) return 14;
            return -1;
        end
        case (off)
            0: return 16;   1: return 17;   2: return 2;   4: return 4;
            6: return 6;    7: return 14;   8: return 1;   10: return 3;
            12: return 5;   14: return 7;   default: return -1;
        endcase
    endfunction

    function automatic bit exp_rom(input logic [19:0] a, input logic [3:0] j);
        int lo = 32'hC0000 + int'(j) * 32'h4000;
        return (int'(a) >= lo) && (int'(a) < lo + 32'h4000);
    endfunction

    function automatic logic [4:0] exp_irq(input logic [2:0] sel, input logic rq);
        logic [4:0] v = '0;
        if (rq) begin
            if (sel == 3'd2) v[0] = 1'b1;
            if (sel == 3'd3) v[1] = 1'b1;
            if (sel == 3'd4) v[2] = 1'b1;
            if (sel == 3'd5) v[3] = 1'b1;
            if (sel == 3'd7) v[4] = 1'b1;
        end
        return v;
    endfunction

    // per-clock comparison of the combinational outputs against the model
    always @(negedge clk) begin
        #1;
        if (!rst) begin
            chk(irq_lines == exp_irq(irq_sel, ide_irq), "R10", irq_lines, exp_irq(irq_sel, ide_irq));
            chk(rom_sel == (mem_rd_req && exp_rom(bus_addr, rom_jmp)), "R9", rom_sel,
                mem_rd_req && exp_rom(bus_addr, rom_jmp));
        end
    end

    task automatic do_io(input bit wr, input logic [15:0] a, input logic [7:0] wd);
        int nstb = 0, ack_at = 0, code, off, base;
        bit hit, ctl;
        logic sc_cmd = 0, sc_ctl = 0, s_rd = 0, s_wr = 0;
        logic [2:0] s_reg = 0;
        logic [15:0] s_w = 0, expw;
        logic [7:0] got = 0;
        string tag;
        @(negedge clk);
        bus_addr = {4'h0, a}; io_wr_req = wr; io_rd_req = !wr; bus_wdata = wd;
        @(negedge clk);
        io_wr_req = 1'b0; io_rd_req = 1'b0;
        for (int i = 1; i <= 12; i++) begin
            if (ide_rd || ide_wr) begin
                if (nstb == 0) begin
                    sc_cmd = ide_cs_cmd; sc_ctl = ide_cs_ctl; s_reg = ide_reg;
                    s_rd = ide_rd; s_wr = ide_wr; s_w = ide_wdata;
                end
                nstb++;
            end
            if (bus_ack && ack_at == 0) begin ack_at = i; got = bus_rdata; end
            if (ack_at != 0) break;
            @(negedge clk);
        end
        base = 32'h200 + int'(io_jmp) * 32'h20;
        hit  = (int'(a) >= base) && (int'(a) < base + 16);
        off  = int'(a) - base;
        tag  = layout_b ? "R6" : "R5";
        if (!hit) begin
            chk(ack_at == 0 && nstb == 0, "R1", ack_at * 16 + nstb, 0);
            return;
        end
        code = exp_code(layout_b, off);
        if (code == 17) begin
            chk(nstb == 0 && ack_at == 1, wr ? "R4" : "R3", ack_at * 16 + nstb, 16);
            if (!wr) chk(got == m_rd, "R3", got, m_rd);
            else m_wr = wd;
        end else if (code < 0) begin
            chk(nstb == 0 && ack_at == 1, "R7", ack_at * 16 + nstb, 16);
            if (!wr) chk(got == 8'h00, "R7", got, 0);
        end else begin
            chk(nstb == S && ack_at == S + 1, "R8", ack_at * 16 + nstb, (S + 1) * 16 + S);
            ctl = (code == 14);
            chk(sc_cmd == !ctl && sc_ctl == ctl && s_rd == !wr && s_wr == wr &&
                s_reg == (ctl ? 3'd6 : (code == 16 ? 3'd0 : 3'(code))), tag,
                {sc_cmd, sc_ctl, s_rd, s_wr, s_reg}, code);
            if (wr) begin
                expw = (code == 16) ? {m_wr, wd} : {8'h00, wd};
                chk(s_w == expw, (code == 16) ? "R4" : "R8", s_w, expw);
            end else begin
                chk(got == ide_rdata[7:0], (code == 16) ? "R2" : tag, got, ide_rdata[7:0]);
                if (code == 16) m_rd = ide_rdata[15:8];
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R11: reset state
        chk(!bus_ack && !ide_rd && !ide_wr, "R11", {bus_ack, ide_rd, ide_wr}, 0);
        do_io(0, 16'h0308, 8'h00);              // R11 read holder cleared (R3 path)
        do_io(1, 16'h0300, 8'h5A);              // R11 write holder cleared, high byte 00

        // layout A full sweep with io window at 0x300
        for (int o = 0; o < 16; o++) begin
            ide_rdata = 16'((o * 16'h1357) ^ 16'hA0C3);
            do_io(0, 16'(16'h0300 + o), 8'h00);
            do_io(1, 16'(16'h0300 + o), 8'(o * 7 + 3));
        end
        // R4 pairing, R2 capture, R3 repeat reads
        do_io(1, 16'h0308, 8'hA5);
        do_io(1, 16'h0300, 8'h3C);
        ide_rdata = 16'hBEEF;
        do_io(0, 16'h0300, 8'h00);
        ide_rdata = 16'h1234;
        do_io(0, 16'h0308, 8'h00);
        do_io(0, 16'h0308, 8'h00);
        do_io(0, 16'h0301, 8'h00);              // other register keeps read holder (R3)
        do_io(0, 16'h0308, 8'h00);

        // layout B sweep with io window at 0x260
        layout_b = 1'b1; io_jmp = 4'd3;
        for (int o = 0; o < 16; o++) begin
            ide_rdata = 16'((o * 16'h0F1D) + 16'h4411);
            do_io(0, 16'(16'h0260 + o), 8'h00);
            do_io(1, 16'(16'h0260 + o), 8'(8'hE0 - o));
        end
        do_io(1, 16'h0261, 8'h77);
        do_io(1, 16'h0263, 8'h99);              // unused offset must not touch holder (R7)
        do_io(1, 16'h0260, 8'h01);
        ide_rdata = 16'hC3D2;
        do_io(0, 16'h0260, 8'h00);
        do_io(0, 16'h0261, 8'h00);

        // R1 boundaries
        do_io(0, 16'h025F, 8'h00);
        do_io(1, 16'h0270, 8'h11);
        do_io(0, 16'h0300, 8'h00);
        do_io(1, 16'h1260, 8'h00);
        io_jmp = 4'd0;
        do_io(0, 16'h0200, 8'h00);
        do_io(0, 16'h020F, 8'h00);
        do_io(0, 16'h0210, 8'h00);
        io_jmp = 4'd15;
        do_io(0, 16'h03EE, 8'h00);
        do_io(0, 16'h03F0, 8'h00);

        // R9 ROM window
        foreach (bus_addr[k]) begin end
        for (int j = 0; j < 16; j += 5) begin
            rom_jmp = 4'(j);
            for (int t = 0; t < 4; t++) begin
                @(negedge clk);
                mem_rd_req = 1'b1;
                bus_addr = 20'(32'hC0000 + j * 32'h4000 + (t - 1) * 32'h2000 + 32'h1ABC * (t & 1));
                #2;
                chk(rom_sel == exp_rom(bus_addr, rom_jmp), "R9", rom_sel, exp_rom(bus_addr, rom_jmp));
                if (rom_sel) chk(rom_offs == bus_addr[13:0], "R9", rom_offs, bus_addr[13:0]);
            end
        end
        @(negedge clk); mem_rd_req = 1'b0;

        // R10 IRQ steering
        for (int s = 0; s < 8; s++) begin
            for (int r = 0; r < 2; r++) begin
                @(negedge clk);
                irq_sel = 3'(s); ide_irq = r[0];
                #2;
                chk(irq_lines == exp_irq(irq_sel, ide_irq), "R10", irq_lines, exp_irq(irq_sel, ide_irq));
            end
        end

        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule